// File: doc/BRIEF.md
# HMAC-SHA1 Two-Chunk Hash Engine

This engine carries out one half of an HMAC-SHA1 evaluation over a fixed 672-bit message. The message is a 512-bit key, XORed with either the inner or the outer pad byte, followed by a 160-bit value. A step select chooses the combination. Select 0 pairs the inner-padded key with the current iteration block. Select 1 pairs the outer-padded key with the previous hash result.

Because the length never changes, the padding is fixed and the message always fills exactly two 512-bit SHA-1 chunks. The engine runs the 80 compression rounds of each chunk at one round per clock. It adds the chaining values back in after each chunk and then presents the digest with a one-cycle ready pulse.

Start and ready are plain control pins with no back-pressure. A controller pulses start while the engine is idle and waits for ready. The data inputs only need to be valid in the cycle start is accepted.

Top module: `hmac_sha1_engine`

## Requirements
- R1: While reset is asserted and after it is released, `ready` is 0 and `digest` is all zeros until the first hash completes.
- R2: With `step_sel`=0, the digest is SHA-1 of the 672-bit message {key XOR 64 copies of 0x36, iter_blk}. The key occupies bits 671:160, and chunk 0 is message bits 671:160, read as big-endian 32-bit words from bit 671 down. Chunk 1 is {message bits 159:0, a single 1 bit, 287 zero bits, the 64-bit length 672}. The digest is {H0,H1,H2,H3,H4}, with H0 in bits 159:128.
- R3: With `step_sel`=1, the digest is SHA-1 of {key XOR 64 copies of 0x5C, prev_hash}, using the same padding and bit order as R2.
- R4: `key`, `step_sel`, `iter_blk` and `prev_hash` are sampled only on the clock edge that accepts `start`. Changing them afterwards has no effect on the result.
- R5: `ready` is high for exactly one cycle. It rises on the 160th rising edge after the edge that accepted `start` (80 rounds for each of the two chunks).
- R6: `digest` changes only on the edge where `ready` rises, and it holds its value at every other time, including during a following hash.
- R7: A `start` pulse that arrives while a hash is running is ignored. It does not restart or delay the running hash, and it does not replace the captured inputs.
- R8: A `start` that is high in the same cycle as `ready` is accepted, so hashes can run back to back with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a hash; accepted only when idle |
| step_sel | input | 1 | 0: inner pad with iter_blk; 1: outer pad with prev_hash |
| key | input | 512 | HMAC key block |
| iter_blk | input | 160 | Current iteration block (used when step_sel=0) |
| prev_hash | input | 160 | Previous hash result (used when step_sel=1) |
| digest | output | 160 | SHA-1 result, held until the next completion |
| ready | output | 1 | One-cycle pulse when digest is updated |

## Verification
The cases hardest to reach from the ports are a start that collides with a hash in flight and a start that coincides with the ready pulse itself. In both cases the outcome depends only on the cycle in which start is sampled. To reach them, the stimulus raises start again well inside the first chunk and again inside the second chunk, each time with different inputs. It also holds start high continuously across a whole hash, so that the only further acceptance happens in the ready cycle. The inputs are changed in mid-hash as well, so that any late re-sampling would show up as a wrong digest.

// File: rtl/hmac_sha1_pkg.sv
package hmac_sha1_pkg;
  localparam int WORD_W  = 32;
  localparam int STATE_W = 160;
  localparam int CHUNK_W = 512;
  localparam int ROUNDS  = 80;
  localparam int LEN_W   = 64;
  localparam int RND_W   = $clog2(ROUNDS);

  localparam logic [STATE_W-1:0] SHA1_IV =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

  typedef enum logic [1:0] {ST_IDLE, ST_CHUNK0, ST_CHUNK1} eng_st_t;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // One compression round on the packed {a,b,c,d,e} state
  function automatic logic [STATE_W-1:0] sha1_round(input logic [STATE_W-1:0] s,
                                                     input logic [31:0] w,
                                                     input logic [RND_W-1:0] t);
    logic [31:0] a, b, c, d, e, f, k, tmp;
    {a, b, c, d, e} = s;
    if (t < 7'd20) begin
      f = (b & c) | (~b & d);
      k = 32'h5A827999;
    end else if (t < 7'd40) begin
      f = b ^ c ^ d;
      k = 32'h6ED9EBA1;
    end else if (t < 7'd60) begin
      f = (b & c) | (b & d) | (c & d);
      k = 32'h8F1BBCDC;
    end else begin
      f = b ^ c ^ d;
      k = 32'hCA62C1D6;
    end
    tmp = rotl(a, 5) + f + e + k + w;
    return {tmp, a, rotl(b, 30), c, d};
  endfunction

  function automatic logic [STATE_W-1:0] add_state(input logic [STATE_W-1:0] x,
                                                    input logic [STATE_W-1:0] y);
    logic [STATE_W-1:0] r;
    for (int i = 0; i < STATE_W / WORD_W; i++)
      r[i*WORD_W +: WORD_W] = x[i*WORD_W +: WORD_W] + y[i*WORD_W +: WORD_W];
    return r;
  endfunction
endpackage

// File: rtl/hmac_msg_prep.sv
module hmac_msg_prep #(
  parameter int         KEY_W     = 512,
  parameter int         VAL_W     = 160,
  parameter logic [7:0] IPAD_BYTE = 8'h36,
  parameter logic [7:0] OPAD_BYTE = 8'h5C,
  localparam int        MSG_W     = KEY_W + VAL_W
) (
  input  logic             step_sel,
  input  logic [KEY_W-1:0] key,
  input  logic [VAL_W-1:0] iter_blk,
  input  logic [VAL_W-1:0] prev_hash,
  output logic [MSG_W-1:0] msg
);
  localparam int NBYTES = KEY_W / 8;
  localparam logic [KEY_W-1:0] IPAD_V = {NBYTES{IPAD_BYTE}};
  localparam logic [KEY_W-1:0] OPAD_V = {NBYTES{OPAD_BYTE}};

  always_comb begin
    if (step_sel) msg = {key ^ OPAD_V, prev_hash};
    else          msg = {key ^ IPAD_V, iter_blk};
  end
endmodule

// File: rtl/sha1_sched.sv
module sha1_sched #(
  parameter int CHUNK_W = 512,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               load,
  input  logic               shift,
  input  logic [CHUNK_W-1:0] chunk,
  output logic [WORD_W-1:0]  w_cur
);
  localparam int NW = CHUNK_W / WORD_W;

  logic [WORD_W-1:0] win [NW];
  logic [WORD_W-1:0] mix, w_new;

  assign mix   = win[13] ^ win[8] ^ win[2] ^ win[0];
  assign w_new = {mix[WORD_W-2:0], mix[WORD_W-1]};
  assign w_cur = win[0];

  // 16-word sliding window: slot 0 is the word used by the current round
  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < NW; i++) win[i] <= chunk[CHUNK_W-1-WORD_W*i -: WORD_W];
    end else if (shift) begin
      for (int i = 0; i < NW - 1; i++) win[i] <= win[i+1];
      win[NW-1] <= w_new;
    end
  end
endmodule

// File: rtl/hmac_sha1_engine.sv
module hmac_sha1_engine
  import hmac_sha1_pkg::*;
#(
  parameter int         KEY_W     = 512,
  parameter int         VAL_W     = 160,
  parameter logic [7:0] IPAD_BYTE = 8'h36,
  parameter logic [7:0] OPAD_BYTE = 8'h5C
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               step_sel,
  input  logic [KEY_W-1:0]   key,
  input  logic [VAL_W-1:0]   iter_blk,
  input  logic [VAL_W-1:0]   prev_hash,
  output logic [STATE_W-1:0] digest,
  output logic               ready
);
  localparam int MSG_W    = KEY_W + VAL_W;
  localparam int ZERO_W   = CHUNK_W - VAL_W - 1 - LEN_W;
  localparam logic [LEN_W-1:0] MSG_LEN = LEN_W'(MSG_W);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(ROUNDS - 1);

  eng_st_t              st_q;
  logic [RND_W-1:0]     rnd_q;
  logic [VAL_W-1:0]     tail_q;
  logic [STATE_W-1:0]   work_q, chain_q, digest_q;
  logic                 ready_q;

  logic [MSG_W-1:0]     msg;
  logic [CHUNK_W-1:0]   chunk1, load_chunk;
  logic [WORD_W-1:0]    w_cur;
  logic [STATE_W-1:0]   work_nxt, chunk_sum;
  logic                 idle, accept, last, sch_load;

  hmac_msg_prep #(
    .KEY_W(KEY_W), .VAL_W(VAL_W), .IPAD_BYTE(IPAD_BYTE), .OPAD_BYTE(OPAD_BYTE)
  ) u_prep (
    .step_sel(step_sel), .key(key), .iter_blk(iter_blk),
    .prev_hash(prev_hash), .msg(msg)
  );

  assign idle       = (st_q == ST_IDLE);
  assign accept     = idle && start;
  assign last       = (rnd_q == LAST_RND);
  assign chunk1     = {tail_q, 1'b1, {ZERO_W{1'b0}}, MSG_LEN};
  assign sch_load   = accept || (st_q == ST_CHUNK0 && last);
  assign load_chunk = idle ? msg[MSG_W-1:VAL_W] : chunk1;

  sha1_sched #(.CHUNK_W(CHUNK_W), .WORD_W(WORD_W)) u_sched (
    .clk(clk), .load(sch_load), .shift(!idle), .chunk(load_chunk), .w_cur(w_cur)
  );

  assign work_nxt  = sha1_round(work_q, w_cur, rnd_q);
  assign chunk_sum = add_state(chain_q, work_nxt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      rnd_q    <= '0;
      tail_q   <= '0;
      work_q   <= '0;
      chain_q  <= '0;
      digest_q <= '0;
      ready_q  <= 1'b0;
    end else begin
      ready_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          tail_q  <= msg[VAL_W-1:0];
          work_q  <= SHA1_IV;
          chain_q <= SHA1_IV;
          rnd_q   <= '0;
          st_q    <= ST_CHUNK0;
        end
        ST_CHUNK0: if (last) begin
          chain_q <= chunk_sum;
          work_q  <= chunk_sum;
          rnd_q   <= '0;
          st_q    <= ST_CHUNK1;
        end else begin
          work_q <= work_nxt;
          rnd_q  <= rnd_q + 7'd1;
        end
        ST_CHUNK1: if (last) begin
          digest_q <= chunk_sum;
          ready_q  <= 1'b1;
          rnd_q    <= '0;
          st_q     <= ST_IDLE;
        end else begin
          work_q <= work_nxt;
          rnd_q  <= rnd_q + 7'd1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign digest = digest_q;
  assign ready  = ready_q;

  // Assertions
  p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_ready_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(st_q == ST_CHUNK1 && last));
  p_digest_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(digest));
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHUNK0 && !last && start) |=> (st_q == ST_CHUNK0 && rnd_q == $past(rnd_q) + 7'd1));
  p_capture_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(tail_q));
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (st_q == ST_CHUNK0 && rnd_q == '0));
  p_round_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q <= LAST_RND);
endmodule

// File: tb/hmac_sha1_engine_tb.sv
module hmac_sha1_engine_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic         step_sel;
  logic [511:0] key;
  logic [159:0] iter_blk, prev_hash;
  logic [159:0] digest;
  logic         ready;

  int nchk = 0, nerr = 0, cyc = 0;
  bit chk_on = 0, done = 0;
  string scen = "R2";

  always #2 clk = ~clk;

  hmac_sha1_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .step_sel(step_sel), .key(key),
    .iter_blk(iter_blk), .prev_hash(prev_hash), .digest(digest), .ready(ready)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  // Behavioural SHA-1 over the fixed 672-bit message
  function automatic logic [159:0] ref_sha1(input logic [671:0] m);
    logic [1023:0] blk;
    logic [31:0] h [5];
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    blk = {m, 1'b1, 287'd0, 64'd672};
    h[0] = 32'h67452301; h[1] = 32'hEFCDAB89; h[2] = 32'h98BADCFE;
    h[3] = 32'h10325476; h[4] = 32'hC3D2E1F0;
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < 16; i++) w[i] = blk[1023 - 512*ch - 32*i -: 32];
      for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
      a = h[0]; b = h[1]; c = h[2]; d = h[3]; e = h[4];
      for (int i = 0; i < 80; i++) begin
        if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
        else if (i < 40) begin f = b ^ c ^ d;                    k = 32'h6ED9EBA1; end
        else if (i < 60) begin f = (b & c) | (b & d) | (c & d);  k = 32'h8F1BBCDC; end
        else             begin f = b ^ c ^ d;                    k = 32'hCA62C1D6; end
        t = rl(a, 5) + f + e + k + w[i];
        e = d; d = c; c = rl(b, 30); b = a; a = t;
      end
      h[0] += a; h[1] += b; h[2] += c; h[3] += d; h[4] += e;
    end
    return {h[0], h[1], h[2], h[3], h[4]};
  endfunction

  // Cycle-by-cycle reference model
  bit           m_busy, m_ready;
  int           m_cnt;
  logic [159:0] m_dig, m_pend;
  string        m_dtag, m_ptag;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_ready = 0; m_dig = '0; m_dtag = "R1";
    end else begin
      m_ready = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == 160) begin
          m_busy = 0; m_ready = 1; m_dig = m_pend; m_dtag = m_ptag;
        end
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_ptag = scen;
        m_pend = step_sel ? ref_sha1({key ^ {64{8'h5C}}, prev_hash})
                          : ref_sha1({key ^ {64{8'h36}}, iter_blk});
      end
    end
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      nchk++;
      if (ready !== m_ready) begin
        nerr++;
        $display("FAIL R5 (%s) ready at cycle %0d: actual=%0b expected=%0b", m_ptag, cyc, ready, m_ready);
      end
      nchk++;
      if (digest !== m_dig) begin
        nerr++;
        $display("FAIL %s digest at cycle %0d: actual=%h expected=%h",
                 m_ready ? m_dtag : "R6", cyc, digest, m_dig);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1; nerr++;
      $display("FAIL R5 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  task automatic rand_inputs();
    for (int i = 0; i < 16; i++) key[32*i +: 32] = $urandom;
    for (int i = 0; i < 5; i++) begin
      iter_blk[32*i +: 32]  = $urandom;
      prev_hash[32*i +: 32] = $urandom;
    end
  endtask

  task automatic one_hash(input bit sel, input string tag);
    @(negedge clk);
    scen = tag; step_sel = sel; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (165) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; step_sel = 1'b0;
    key = '0; iter_blk = '0; prev_hash = '0;
    repeat (3) @(negedge clk);
    nchk++;
    if (ready !== 1'b0 || digest !== '0) begin
      nerr++;
      $display("FAIL R1 reset: actual ready=%0b digest=%h expected ready=0 digest=0", ready, digest);
    end
    rst_n = 1'b1;
    chk_on = 1;

    // R2 / R3 on fixed and random patterns
    one_hash(1'b0, "R2");
    key = '1; iter_blk = '1; prev_hash = '1;
    one_hash(1'b1, "R3");
    rand_inputs(); one_hash(1'b0, "R2");
    rand_inputs(); one_hash(1'b1, "R3");

    // R4: inputs change after acceptance
    rand_inputs();
    @(negedge clk); scen = "R4"; step_sel = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    rand_inputs(); step_sel = 1'b1;
    repeat (150) @(negedge clk);

    // R7: start pulses in both chunks are ignored
    rand_inputs();
    @(negedge clk); scen = "R7"; step_sel = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    rand_inputs(); step_sel = 1'b0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (70) @(negedge clk);
    rand_inputs(); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (60) @(negedge clk);

    // R8: start held high; second acceptance in the ready cycle
    rand_inputs();
    @(negedge clk); scen = "R8"; step_sel = 1'b0; start = 1'b1;
    repeat (10) @(negedge clk);
    rand_inputs(); step_sel = 1'b1;
    repeat (160) @(negedge clk);
    start = 1'b0;
    repeat (170) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule